// File: doc/BRIEF.md
# I2S Master Transmitter

This block is a transmit-only serializer that acts as the bit-clock and word-select master of a two-channel I2S link. It runs from the master clock, divides that clock down to a bit clock whose half period is set by an 8-bit ratio value, and sends stereo frames. Each frame has a left slot followed by a right slot. The data is taken from a show-ahead FIFO that holds one 32-bit word per channel.

The slot width comes from a 6-bit resolution input. Only the low-order bits of each FIFO word, up to that width, are sent, most significant of those bits first. Enabling the block always sends one frame of silence before any queued word leaves the FIFO. Disabling it lets the current frame finish and then parks every output low. If the FIFO is empty when a slot starts, that slot is sent as silence and the FIFO is left untouched. With a master clock of 256 times the sample rate, a ratio of 0 gives 32-bit slots and a ratio of 2 gives 16-bit slots.

Top module: `pcm_i2s_tx`

## Requirements
- R1: While running, bclk is low for exactly ratio+2 master-clock cycles and then high for exactly ratio+2 cycles, giving a period of 2*(ratio+2). bclk is low when enable starts the block.
- R2: sdata and lrclk change only in the master-clock cycle in which bclk falls.
- R3: The slot width W equals res when res is 2 to 32. Any other res value gives W = 32. A slot sends word bits W-1 down to 0 in that order, and FIFO bits at or above W are never sent.
- R4: lrclk is 0 for the left slot and 1 for the right slot. It takes the level of the next slot while the last bit of the current slot is being sent, so each slot's first bit follows one bit-clock after the lrclk edge.
- R5: After enable rises from idle, the first frame is all zeros on both slots and no pop is issued during it.
- R6: Each later frame takes its left word and then its right word from consecutive FIFO entries. Each pop is a single-cycle pulse in the cycle whose clock edge makes bclk fall at the start of that slot.
- R7: If fifo_empty is 1 when a slot starts, that slot sends zeros and no pop is issued.
- R8: When enable is low at the end of a frame (the bclk fall after the right slot's last bit), the block stops. bclk, lrclk and sdata stay low, and no further bits or pops occur until enable is raised again.
- R9: During reset, bclk, lrclk, sdata and fifo_pop are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| ratio | input | 8 | Divider setting, bclk half period = ratio+2 mclk cycles |
| res | input | 6 | Slot width in bits (2..32, other values mean 32) |
| fifo_data | input | 32 | Head word of the show-ahead FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Word select, 0 = left, 1 = right |
| sdata | output | 1 | Serial data, changes on the bclk falling edge |
| fifo_pop | output | 1 | One-cycle request to remove the head word |

## Verification
The hardest case to reach from the ports is a FIFO that runs dry partway through a frame, so that a left word is sent but the right slot must fall back to silence without a pop. The stimulus preloads an odd number of words, which makes this happen in the last frame. In the same run the enable is dropped during that frame's right slot, so the stop at the frame boundary and the underrun are checked together. Other runs use widths of 2, 16 and 32 and out-of-range width codes. They load words with the bits above the slot width set, to show that those bits never reach sdata.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
    localparam int WORD_W  = 32;
    localparam int RATIO_W = 8;
    localparam int RES_W   = 6;
    localparam int IDX_W   = $clog2(WORD_W);

    typedef enum logic {
        SLOT_LEFT  = 1'b0,
        SLOT_RIGHT = 1'b1
    } slot_e;

    typedef struct packed {
        logic             running;
        logic             silent;   // first frame after enable
        slot_e            ch;
        logic [IDX_W-1:0] bit_i;    // bit position inside the slot
        logic [IDX_W-1:0] last;     // slot width minus one
    } seq_t;

    // Index of the last bit of a slot for a given width code.
    function automatic logic [IDX_W-1:0] slot_last(input logic [RES_W-1:0] r);
        if (r < RES_W'(2) || int'(r) > WORD_W)
            return IDX_W'(WORD_W - 1);
        return IDX_W'(r - RES_W'(1));
    endfunction
endpackage

// File: rtl/pcm_bclk_div.sv
module pcm_bclk_div #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [RATIO_W-1:0] ratio,
    output logic               bclk,
    output logic               fall
);
    localparam int CNT_W = RATIO_W + 1;

    logic [CNT_W-1:0] cnt;
    logic             tick;

    // half period is ratio+2 cycles: count 0 .. ratio+1
    assign tick = (cnt == ({1'b0, ratio} + CNT_W'(1)));
    assign fall = run & tick & bclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt  <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pcm_word_fetch.sv
module pcm_word_fetch
    import pcm_tx_pkg::*;
(
    input  logic              load,
    input  logic              force_zero,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_data,
    output logic [WORD_W-1:0] word,
    output logic              pop
);
    logic take;

    assign take = ~force_zero & ~fifo_empty;
    assign word = take ? fifo_data : '0;
    assign pop  = load & take;
endmodule

// File: rtl/pcm_slot_seq.sv
module pcm_slot_seq
    import pcm_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              fall,
    input  logic [RES_W-1:0]  res,
    input  logic [WORD_W-1:0] word_in,
    output logic              running,
    output logic              load,
    output logic              force_zero,
    output logic              lrclk,
    output logic              sdata
);
    seq_t              st;
    logic [WORD_W-1:0] word;
    logic              at_last;
    logic              stop;

    assign running    = st.running;
    assign at_last    = (st.bit_i == st.last);
    assign stop       = fall & at_last & (st.ch == SLOT_RIGHT) & ~tx_en;
    assign load       = st.running & fall & at_last & ~stop;
    // the right slot of the silent frame stays silent; the next frame is live
    assign force_zero = (st.ch == SLOT_LEFT) & st.silent;

    assign sdata = st.running & word[st.last - st.bit_i];
    assign lrclk = st.running & (at_last ? ~st.ch : st.ch);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '{running: 1'b0, silent: 1'b0, ch: SLOT_LEFT, bit_i: '0, last: '0};
            word <= '0;
        end else if (!st.running) begin
            if (tx_en) begin
                st   <= '{running: 1'b1, silent: 1'b1, ch: SLOT_LEFT,
                          bit_i: '0, last: slot_last(res)};
                word <= '0;
            end
        end else if (fall) begin
            if (stop) begin
                st   <= '{running: 1'b0, silent: 1'b0, ch: SLOT_LEFT, bit_i: '0, last: '0};
                word <= '0;
            end else if (at_last) begin
                st.bit_i <= '0;
                st.ch    <= (st.ch == SLOT_LEFT) ? SLOT_RIGHT : SLOT_LEFT;
                word     <= word_in;
                if (st.ch == SLOT_RIGHT) begin
                    st.silent <= 1'b0;
                    st.last   <= slot_last(res);
                end
            end else begin
                st.bit_i <= st.bit_i + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/pcm_i2s_tx.sv
module pcm_i2s_tx
    import pcm_tx_pkg::*;
(
    input  logic               mclk,
    input  logic               rst,
    input  logic               tx_en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [RES_W-1:0]   res,
    input  logic [WORD_W-1:0]  fifo_data,
    input  logic               fifo_empty,
    output logic               bclk,
    output logic               lrclk,
    output logic               sdata,
    output logic               fifo_pop
);
    logic              running;
    logic              fall;
    logic              load;
    logic              force_zero;
    logic [WORD_W-1:0] next_word;

    pcm_bclk_div #(.RATIO_W(RATIO_W)) div_u (
        .clk   (mclk),
        .rst   (rst),
        .run   (running),
        .ratio (ratio),
        .bclk  (bclk),
        .fall  (fall)
    );

    pcm_word_fetch fetch_u (
        .load       (load),
        .force_zero (force_zero),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .word       (next_word),
        .pop        (fifo_pop)
    );

    pcm_slot_seq seq_u (
        .clk        (mclk),
        .rst        (rst),
        .tx_en      (tx_en),
        .fall       (fall),
        .res        (res),
        .word_in    (next_word),
        .running    (running),
        .load       (load),
        .force_zero (force_zero),
        .lrclk      (lrclk),
        .sdata      (sdata)
    );
endmodule

// File: rtl/pcm_i2s_tx_chk.sv
module pcm_i2s_tx_chk (
    input logic mclk,
    input logic rst,
    input logic bclk,
    input logic lrclk,
    input logic sdata,
    input logic fifo_pop,
    input logic fifo_empty
);
    // R7: a pop is never issued against an empty FIFO
    a_r7_pop_needs_data: assert property (@(posedge mclk) disable iff (rst)
        fifo_pop |-> !fifo_empty);

    // R2: serial data moves only with a falling bit clock
    a_r2_sdata_on_fall: assert property (@(posedge mclk) disable iff (rst)
        !$stable(sdata) |-> $fell(bclk));

    // R2: word select moves only with a falling bit clock
    a_r2_lrclk_on_fall: assert property (@(posedge mclk) disable iff (rst)
        !$stable(lrclk) |-> $fell(bclk));

    // R6: a pop is followed by the falling edge that opens the slot
    a_r6_pop_at_fall: assert property (@(posedge mclk) disable iff (rst)
        fifo_pop |=> $fell(bclk));

    // R1: a high phase lasts at least two cycles
    a_r1_bclk_hold: assert property (@(posedge mclk) disable iff (rst)
        $rose(bclk) |=> bclk);
endmodule

bind pcm_i2s_tx pcm_i2s_tx_chk chk_u (
    .mclk       (mclk),
    .rst        (rst),
    .bclk       (bclk),
    .lrclk      (lrclk),
    .sdata      (sdata),
    .fifo_pop   (fifo_pop),
    .fifo_empty (fifo_empty)
);

// File: tb/pcm_i2s_tx_tb_top.sv
module pcm_i2s_tx_tb_top;
    logic        mclk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0;
    logic [7:0]  ratio = '0;
    logic [5:0]  res = '0;
    logic [31:0] fifo_data;
    logic        fifo_empty;
    logic        bclk, lrclk, sdata, fifo_pop;

    logic [31:0] mem [0:7];
    int          wr_cnt = 0;
    int          rd_ptr;

    int checks = 0;
    int fails  = 0;

    // expected {lrclk, sdata} per bit
    logic [1:0] exp_q [$];
    int cur_ratio = 0;
    int cur_w     = 32;
    int rises     = 0;
    int last_rise = 0;
    int cyc       = 0;
    int early     = 0;
    int extra     = 0;
    bit first     = 1'b1;
    bit prev_b = 1'b0, prev_l = 1'b0, prev_d = 1'b0;
    bit done      = 1'b0;

    always #4 mclk = ~mclk;

    pcm_i2s_tx dut_i (
        .mclk       (mclk),
        .rst        (rst),
        .tx_en      (tx_en),
        .ratio      (ratio),
        .res        (res),
        .fifo_data  (fifo_data),
        .fifo_empty (fifo_empty),
        .bclk       (bclk),
        .lrclk      (lrclk),
        .sdata      (sdata),
        .fifo_pop   (fifo_pop)
    );

    // FIFO model
    assign fifo_empty = (rd_ptr >= wr_cnt);
    assign fifo_data  = mem[rd_ptr[2:0]];

    always @(posedge mclk) begin
        if (rst) rd_ptr <= 0;
        else if (fifo_pop) rd_ptr <= rd_ptr + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_slot(input logic [31:0] w, input bit ch, input int width);
        for (int b = 0; b < width; b++) begin
            logic lr;
            lr = (b == width - 1) ? ~ch : ch;
            exp_q.push_back({lr, w[width-1-b]});
        end
    endtask

    // monitor
    always @(negedge mclk) begin
        cyc++;
        if (!rst) begin
            if ((sdata != prev_d || lrclk != prev_l) && !(prev_b && !bclk))
                check(1'b0, "R2", "output moved without bclk fall", int'(bclk), 0);
            if (fifo_pop && rises < 2 * cur_w)
                early++;
            if (bclk && !prev_b) begin
                if (!first)
                    check(cyc - last_rise == 2 * (cur_ratio + 2), "R1",
                          "bclk period", cyc - last_rise, 2 * (cur_ratio + 2));
                first = 1'b0;
                last_rise = cyc;
                rises++;
                if (exp_q.size() == 0) begin
                    extra++;
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    check(lrclk == e[1], "R4", "lrclk bit", int'(lrclk), int'(e[1]));
                    check(sdata == e[0], "R3", "sdata bit", int'(sdata), int'(e[0]));
                end
            end
        end
        prev_b = bclk;
        prev_l = lrclk;
        prev_d = sdata;
    end

    task automatic run_case(input int r, input int rs, input int w, input int n);
        int frames;
        @(negedge mclk);
        rst = 1'b1; tx_en = 1'b0;
        ratio = 8'(r); res = 6'(rs); wr_cnt = n;
        cur_ratio = r; cur_w = w; rises = 0; first = 1'b1; early = 0; extra = 0;
        exp_q.delete();
        push_slot(32'h0, 1'b0, w);
        push_slot(32'h0, 1'b1, w);
        frames = (n + 1) / 2;
        if (frames < 1) frames = 1;
        for (int f = 0; f < frames; f++) begin
            push_slot((2*f < n) ? mem[2*f] : 32'h0, 1'b0, w);
            push_slot((2*f+1 < n) ? mem[2*f+1] : 32'h0, 1'b1, w);
        end
        repeat (3) @(negedge mclk);
        rst = 1'b0;
        @(negedge mclk);
        tx_en = 1'b1;
        while (exp_q.size() > w) @(negedge mclk);
        tx_en = 1'b0;
        while (exp_q.size() > 0) @(negedge mclk);
        repeat (8 * (r + 2)) @(negedge mclk);
        check(!bclk && !lrclk && !sdata, "R8", "idle outputs",
              int'({bclk, lrclk, sdata}), 0);
        check(extra == 0, "R8", "bits after stop", extra, 0);
        check(rd_ptr == n, "R6", "pop count", rd_ptr, n);
        check(early == 0, "R5", "pops during silent frame", early, 0);
    endtask

    initial begin
        repeat (3) @(negedge mclk);
        // R9: reset state
        check(!bclk && !lrclk && !sdata && !fifo_pop, "R9", "reset outputs",
              int'({bclk, lrclk, sdata, fifo_pop}), 0);

        // R3/R6: 32-bit slots, ratio 0
        mem[0] = 32'h8000_0001; mem[1] = 32'hA5A5_5A5A;
        mem[2] = 32'h1234_5678; mem[3] = 32'hFFFF_0000;
        run_case(0, 32, 32, 4);

        // R3: 16-bit slots, upper bits must be dropped
        mem[0] = 32'hDEAD_8001; mem[1] = 32'hBEEF_7FFE;
        mem[2] = 32'h5555_C3C3; mem[3] = 32'hAAAA_0F0F;
        run_case(2, 16, 16, 4);

        // R7: FIFO empty from the start, only silence and no pops
        run_case(5, 8, 8, 0);

        // R7/R8: odd word count, right slot of last frame underruns; res 0 means 32
        mem[0] = 32'h0F0F_F0F0; mem[1] = 32'h7000_000E; mem[2] = 32'hC000_0003;
        run_case(1, 0, 32, 3);

        // R3: smallest width, and width code above 32 means 32
        mem[0] = 32'hFFFF_FFFE; mem[1] = 32'h0000_0001;
        mem[2] = 32'h0000_0003; mem[3] = 32'h0000_0002;
        run_case(0, 2, 2, 4);
        mem[0] = 32'h9ABC_DEF0; mem[1] = 32'h1357_9BDF;
        run_case(3, 45, 32, 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge mclk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule